// File: doc/BRIEF.md
# Accumulator-Phase Tapped Clock Generator

This block produces the clock for a digital pulse-width modulator as a train of single-tick pulses whose spacing is a programmable number of delay steps. A ring of 2^m delay cells is modelled with one fast reference tick per cell delay. A position counter stands for the pulse travelling round the ring. A tap register names the cell whose passage emits the next output pulse. After each output pulse the tap moves forward by a step value k, wrapping modulo 2^m. The next pulse therefore comes k ticks later, or a full ring later when k is zero.

The frequency request is the sum of a fundamental word and a spread-spectrum offset. The upper bits of that sum index a computed table. The table turns the request into k, because the output frequency falls as k grows. A controller moves the fundamental word with its operating point and dithers the offset once per switching cycle. The pulse spacing follows both, one period boundary later.

Top module: `apt_clkgen`

## Requirements
- R1: During reset `clk_pulse` is 0 and `tap_sel` is 0. After reset is released, the first pulse appears exactly 2^RING_BITS ticks later, whatever the request.
- R2: When k is 0, consecutive pulses are 2^RING_BITS ticks apart and `tap_sel` does not change.
- R3: When k is non-zero, consecutive pulses are k ticks apart.
- R4: At each pulse `tap_sel` advances by k modulo 2^RING_BITS and holds between pulses. With 64 cells, k = 30 and a start from 0, the taps at successive pulses are 0, 30, 60, 26, 56.
- R5: The request is `fsw_f + fss` taken at FREQ_W+1 bits without wrap. The table index is the upper MAP_BITS bits of that sum.
- R6: For a non-zero index i, k = floor(K_NUM / i) whenever that quotient lies in 1 .. 2^RING_BITS-1. With the defaults, index 16 gives 30, index 8 gives 60, index 20 gives 24 and index 31 gives 15.
- R7: An index of 0, or a quotient of 2^RING_BITS or more, gives k = 0, a full-ring period.
- R8: A request changed after a pulse does not alter the period that pulse started. It sets the length of the period that starts at the following pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_tick | input | 1 | Fast reference tick; one period is one cell delay |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsw_f | input | FREQ_W | Fundamental frequency word |
| fss | input | FREQ_W | Spread-spectrum offset added to the fundamental word |
| clk_pulse | output | 1 | One-tick output clock pulse |
| tap_sel | output | RING_BITS | Current tap cell index |

## Verification
The bench builds the block with its defaults: a 64-cell ring, 8-bit request words, a 5-bit table index and a table numerator of 480. Taps 30, 60 and 15 and the full-ring fallback can all be reached with ordinary input values. The default ring is the 64-cell case, so the documented tap sequence 0, 30, 60, 26, 56 appears directly on `tap_sel`. Sums above 255 push the index to 16 and beyond only when both words contribute, so the carry into the ninth bit can be observed at the ports. Indices 6 and 7 give quotients above 63 and exercise the out-of-range fallback.

// File: rtl/apt_pkg.sv
package apt_pkg;

  // Step value for a table index: 0 means the full-ring period.
  function automatic int k_from_index(input int idx, input int num, input int ring);
    int q;
    if (idx == 0) return 0;
    q = num / idx;
    if (q >= ring) return 0;
    return q;
  endfunction

  // Ticks between pulses for a given step value.
  function automatic int period_of(input int k, input int ring);
    return (k == 0) ? ring : k;
  endfunction

endpackage

// File: rtl/apt_phase_ring.sv
module apt_phase_ring #(
  parameter int RING_BITS = 6
) (
  input  logic                 clk_tick,
  input  logic                 rst_n,
  output logic [RING_BITS-1:0] pos_o,
  output logic                 armed_o
);
  localparam logic [RING_BITS-1:0] LAST_CELL = '1;

  logic [RING_BITS-1:0] pos_q;
  logic                 armed_q;
  logic                 wrap_evt;

  assign wrap_evt = (pos_q == LAST_CELL);

  always_ff @(posedge clk_tick or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      pos_q <= pos_q + 1'b1;
      if (wrap_evt) armed_q <= 1'b1;
    end
  end

  assign pos_o   = pos_q;
  assign armed_o = armed_q;

  // R1: once armed, the flag never drops until reset
  p_armed_sticky_r1: assert property (@(posedge clk_tick) disable iff (!rst_n)
    armed_q |=> armed_q);

endmodule

// File: rtl/apt_freq_map.sv
module apt_freq_map #(
  parameter int FREQ_W    = 8,
  parameter int MAP_BITS  = 5,
  parameter int RING_BITS = 6,
  parameter int K_NUM     = 480
) (
  input  logic                 clk_tick,
  input  logic                 rst_n,
  input  logic [FREQ_W-1:0]    fsw_f,
  input  logic [FREQ_W-1:0]    fss,
  output logic [RING_BITS-1:0] k_o
);
  localparam int SUM_W   = FREQ_W + 1;
  localparam int ENTRIES = 2 ** MAP_BITS;
  localparam int RING    = 2 ** RING_BITS;

  logic [SUM_W-1:0]     req_q;
  logic [MAP_BITS-1:0]  idx;
  logic [RING_BITS-1:0] lut [ENTRIES];

  always_ff @(posedge clk_tick or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= {1'b0, fsw_f} + {1'b0, fss};
  end

  assign idx = req_q[SUM_W-1 -: MAP_BITS];

  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_lut
    assign lut[gi] = RING_BITS'(apt_pkg::k_from_index(gi, K_NUM, RING));
  end

  assign k_o = lut[idx];

  // R6: a non-zero step is the largest integer whose product with the index stays within K_NUM
  p_k_quotient_r6: assert property (@(posedge clk_tick) disable iff (!rst_n)
    (k_o != '0) |-> ((int'(k_o) * int'(idx) <= K_NUM) &&
                     ((int'(k_o) + 1) * int'(idx) > K_NUM)));

  // R7: an empty index always falls back to the full ring
  p_zero_index_r7: assert property (@(posedge clk_tick) disable iff (!rst_n)
    (idx == '0) |-> (k_o == '0));

endmodule

// File: rtl/apt_tap_accum.sv
module apt_tap_accum #(
  parameter int RING_BITS = 6
) (
  input  logic                 clk_tick,
  input  logic                 rst_n,
  input  logic [RING_BITS-1:0] pos_i,
  input  logic                 armed_i,
  input  logic [RING_BITS-1:0] k_i,
  output logic [RING_BITS-1:0] sel_o,
  output logic                 fire_o
);
  logic [RING_BITS-1:0] sel_q;
  logic                 fire;

  assign fire = armed_i && (pos_i == sel_q);

  always_ff @(posedge clk_tick or negedge rst_n) begin
    if (!rst_n)    sel_q <= '0;
    else if (fire) sel_q <= sel_q + k_i;
  end

  assign sel_o  = sel_q;
  assign fire_o = fire;

  // R4: the tap only moves on a pulse
  p_tap_hold_r4: assert property (@(posedge clk_tick) disable iff (!rst_n)
    !fire |=> $stable(sel_q));

endmodule

// File: rtl/apt_clkgen.sv
module apt_clkgen #(
  parameter int RING_BITS = 6,
  parameter int FREQ_W    = 8,
  parameter int MAP_BITS  = 5,
  parameter int K_NUM     = 480
) (
  input  logic                 clk_tick,
  input  logic                 rst_n,
  input  logic [FREQ_W-1:0]    fsw_f,
  input  logic [FREQ_W-1:0]    fss,
  output logic                 clk_pulse,
  output logic [RING_BITS-1:0] tap_sel
);
  localparam int RING = 2 ** RING_BITS;

  logic [RING_BITS-1:0] ring_pos;
  logic                 ring_armed;
  logic [RING_BITS-1:0] step_k;
  logic [RING_BITS-1:0] tap_q;
  logic                 pulse_evt;

  apt_phase_ring #(.RING_BITS(RING_BITS)) u_ring (
    .clk_tick (clk_tick),
    .rst_n    (rst_n),
    .pos_o    (ring_pos),
    .armed_o  (ring_armed)
  );

  apt_freq_map #(
    .FREQ_W    (FREQ_W),
    .MAP_BITS  (MAP_BITS),
    .RING_BITS (RING_BITS),
    .K_NUM     (K_NUM)
  ) u_map (
    .clk_tick (clk_tick),
    .rst_n    (rst_n),
    .fsw_f    (fsw_f),
    .fss      (fss),
    .k_o      (step_k)
  );

  apt_tap_accum #(.RING_BITS(RING_BITS)) u_accum (
    .clk_tick (clk_tick),
    .rst_n    (rst_n),
    .pos_i    (ring_pos),
    .armed_i  (ring_armed),
    .k_i      (step_k),
    .sel_o    (tap_q),
    .fire_o   (pulse_evt)
  );

  assign clk_pulse = pulse_evt;
  assign tap_sel   = tap_q;

  // Observation counters for the period and start-up checks
  logic [RING_BITS:0]   gap_cnt;
  logic [RING_BITS:0]   boot_cnt;
  logic [RING_BITS-1:0] k_at_pulse;
  logic                 seen_pulse;

  always_ff @(posedge clk_tick or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt    <= '0;
      boot_cnt   <= '0;
      k_at_pulse <= '0;
      seen_pulse <= 1'b0;
    end else begin
      if (boot_cnt != (RING_BITS+1)'(RING)) boot_cnt <= boot_cnt + 1'b1;
      if (pulse_evt) begin
        gap_cnt    <= (RING_BITS+1)'(1);
        k_at_pulse <= step_k;
        seen_pulse <= 1'b1;
      end else if (gap_cnt != '1) begin
        gap_cnt <= gap_cnt + 1'b1;
      end
    end
  end

  // R1: no pulse before a full ring has elapsed since reset
  p_no_early_pulse_r1: assert property (@(posedge clk_tick) disable iff (!rst_n)
    pulse_evt |-> (boot_cnt == (RING_BITS+1)'(RING)) || seen_pulse);

  // R2, R3: spacing between pulses matches the step sampled at the previous pulse
  p_period_r3: assert property (@(posedge clk_tick) disable iff (!rst_n)
    (pulse_evt && seen_pulse) |->
      (int'(gap_cnt) == apt_pkg::period_of(int'(k_at_pulse), RING)));

endmodule

// File: tb/apt_clkgen_tb.sv
module apt_clkgen_tb;
  localparam int RB   = 6;
  localparam int FW   = 8;
  localparam int MB   = 5;
  localparam int KN   = 480;
  localparam int RING = 64;

  logic          clk_tick = 1'b0;
  logic          rst_n    = 1'b0;
  logic [FW-1:0] fsw_f    = '0;
  logic [FW-1:0] fss      = '0;
  logic          clk_pulse;
  logic [RB-1:0] tap_sel;

  int n_checks = 0;
  int n_fail   = 0;
  int tick     = 0;

  apt_clkgen #(.RING_BITS(RB), .FREQ_W(FW), .MAP_BITS(MB), .K_NUM(KN)) u_dut (
    .clk_tick  (clk_tick),
    .rst_n     (rst_n),
    .fsw_f     (fsw_f),
    .fss       (fss),
    .clk_pulse (clk_pulse),
    .tap_sel   (tap_sel)
  );

  always #10 clk_tick = ~clk_tick;   // 50 MHz

  always @(posedge clk_tick) if (rst_n) tick <= tick + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected step from the requirement text: sum, upper bits, quotient, fallback
  function automatic int exp_k(input int f, input int s);
    int sum, idx, q;
    sum = f + s;
    idx = sum / (2 ** (FW + 1 - MB));
    if (idx == 0) return 0;
    q = KN / idx;
    return (q < RING) ? q : 0;
  endfunction

  function automatic int exp_period(input int k);
    return (k == 0) ? RING : k;
  endfunction

  task automatic do_reset(input int f, input int s);
    @(negedge clk_tick);
    rst_n = 1'b0;
    fsw_f = FW'(f);
    fss   = FW'(s);
    repeat (3) @(negedge clk_tick);
    chk(clk_pulse == 1'b0, "R1 pulse in reset", int'(clk_pulse), 0);
    chk(tap_sel == '0, "R1 tap in reset", int'(tap_sel), 0);
    tick  = 0;
    rst_n = 1'b1;
  endtask

  // Returns tick count at the next pulse, sampled on a falling edge
  task automatic wait_pulse(output int at, output int tap);
    int guard = 0;
    do begin
      @(negedge clk_tick);
      guard++;
    end while (!clk_pulse && guard < 300);
    if (!clk_pulse) chk(1'b0, "watchdog pulse", guard, RING);
    at  = tick;
    tap = int'(tap_sel);
  endtask

  task automatic t_startup;
    int at, tp;
    do_reset(200, 60);
    wait_pulse(at, tp);
    chk(at == RING, "R1 first pulse delay", at, RING);
    chk(tp == 0, "R1 first tap", tp, 0);
  endtask

  task automatic t_full_ring;
    int a0, a1, t0, t1;
    do_reset(0, 0);
    wait_pulse(a0, t0);
    wait_pulse(a1, t1);
    chk(a1 - a0 == RING, "R2 full-ring period", a1 - a0, RING);
    chk(t1 == 0 && t0 == 0, "R2 tap fixed", t1, 0);
  endtask

  task automatic t_tap_walk;
    int exp_tap[5] = '{0, 30, 60, 26, 56};
    int a, tp, prev;
    do_reset(200, 60);
    prev = 0;
    for (int i = 0; i < 5; i++) begin
      wait_pulse(a, tp);
      chk(tp == exp_tap[i], "R4 tap sequence", tp, exp_tap[i]);
      if (i > 0) chk(a - prev == 30, "R3 period k=30", a - prev, 30);
      prev = a;
    end
  endtask

  task automatic t_map(input int f, input int s, input string req);
    int a0, a1, a2, t0, e;
    @(negedge clk_tick);
    fsw_f = FW'(f);
    fss   = FW'(s);
    wait_pulse(a0, t0);
    wait_pulse(a1, t0);
    wait_pulse(a2, t0);
    e = exp_period(exp_k(f, s));
    chk(a2 - a1 == e, req, a2 - a1, e);
  endtask

  task automatic t_mapping;
    do_reset(0, 0);
    t_map(128, 0,   "R6 index 8 k=60");
    t_map(255, 255, "R6 index 31 k=15");
    t_map(250, 70,  "R6 index 20 k=24");
    t_map(112, 0,   "R7 quotient 68 falls back");
    t_map(15, 0,    "R7 index 0 falls back");
    t_map(100, 0,   "R5 fundamental alone");
    t_map(100, 156, "R5 sum carries to index 16");
  endtask

  task automatic t_late_change;
    int a0, a1, a2, a3, tp;
    do_reset(200, 60);
    wait_pulse(a0, tp);
    wait_pulse(a0, tp);
    fsw_f = FW'(128);
    fss   = FW'(0);
    wait_pulse(a1, tp);
    wait_pulse(a2, tp);
    chk(a1 - a0 == 30, "R8 running period kept", a1 - a0, 30);
    chk(a2 - a1 == 60, "R8 next period uses new request", a2 - a1, 60);
    fsw_f = FW'(0);
    wait_pulse(a3, tp);
    chk(a3 - a2 == 60, "R8 change mid-period deferred", a3 - a2, 60);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_tick);
    chk(1'b0, "watchdog global", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    t_startup();
    t_full_ring();
    t_tap_walk();
    t_mapping();
    t_late_change();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule